// File: doc/BRIEF.md
# Parallel Flash Programming Mode Controller

This block models the pin-level programming interface of a small on-chip code flash of 1K bytes. An external programmer drives a high-voltage-enable flag, a logic-level reset pin, an active-low program strobe, four mode-select pins, an address-increment pin and an 8-bit data port. The block decodes which programming operation is requested and steps an internal 10-bit address counter. It runs self-timed byte writes and lock-bit writes while a ready/busy pin reports progress, and it runs a chip erase once the strobe has been held low long enough. Data polling lets the programmer see when a write has finished, and two lock bits protect the array.

A register-array model stands in for the flash cells inside the block, and the commands sent to it are brought out on the array-side ports. Reads return array data, the data-polling value while a write is in flight, all-ones when verify is locked, or one of three fixed identification bytes in signature mode. All pins are sampled on the system clock, and all timing is given as parameterised cycle counts.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A rising edge on `rst_pin` clears the address counter to 0. Each rising edge on `incr_pin` adds one to it, and the count wraps from 1023 to 0.
- R2: With `rst_pin` high, the mode is taken from `mode_sel` (bit 3 down to bit 0). With `hv_en` high: 4'b0111 is write code, 4'b1111 is write lock 1, 4'b1100 is write lock 2 and 4'b1000 is chip erase. With `hv_en` low and `strobe_n` high: 4'b0011 is read code and 4'b0000 is read signature. Any other combination is idle. In idle and in the write modes, `dout` is 8'hFF, and a strobe pulse has no effect.
- R3: In a write mode, `din` is captured at the first clock at which `strobe_n` is seen low. `ready` goes low at the first clock at which `strobe_n` is seen high again. It stays low for exactly WRITE_CYC clocks, which never exceeds WRITE_MAX_CYC.
- R4: A completed code write stores the old byte AND the captured data. It can only clear bits.
- R5: While a code write is in flight, a read-code access to the address being written returns the inverse of bit 7 of the written data on bit 7, and the old stored bits 6..0 on the other bits. Once `ready` is high again, the true byte is returned.
- R6: Holding `strobe_n` low in chip-erase mode for ERASE_CYC consecutive clocks sets every byte to 8'hFF and clears both lock bits. A shorter low time changes nothing.
- R7: With lock 1 set, a code write pulse is ignored: `ready` stays high and the stored byte is unchanged.
- R8: With both lock 1 and lock 2 set, read-code returns 8'hFF. Once a lock bit is set, only chip erase clears it.
- R9: In signature mode, addresses 0, 1 and 2 return SIG0, SIG1 and SIG2. Every other address returns 8'hFF.
- R10: While `ready` is low, `incr_pin` edges and new strobe pulses are ignored. The address does not move, and no second write starts.
- R11: After reset, `ready` is high, the address is 0, no array command is active, and `dout` is 8'hFF until a read mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hv_en | input | 1 | High-voltage programming enable flag |
| rst_pin | input | 1 | Logic-level reset pin; its rising edge clears the address |
| strobe_n | input | 1 | Active-low program strobe |
| mode_sel | input | 4 | Mode-select pins |
| incr_pin | input | 1 | Address-increment pulse pin |
| din | input | 8 | Data port input |
| dout | output | 8 | Read-data port |
| ready | output | 1 | High when ready, low while a write is timing |
| arr_addr | output | 10 | Address sent to the cell array |
| arr_wdata | output | 8 | Write data sent to the cell array |
| arr_wr | output | 1 | One-clock byte program command |
| arr_lock_wr | output | 2 | One-clock lock-bit program commands (bit 0 is lock 1) |
| arr_erase | output | 1 | One-clock chip erase command |

## Verification
A counter that slips shows up at the next read as a byte from the wrong address. Wrapping and holding during a write are checked by reading a distinctive byte after 1023 or more increments. A wrong busy count or a missing capture is seen on `ready` within one clock of the expected edge, and a wrong AND merge or polling value is seen on `dout` at the first read after the write. If the lock state is corrupted, a write that should be refused pulls `ready` low at once, and a verify that should be blocked returns real data.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [2:0] {
    FP_IDLE,
    FP_WR_CODE,
    FP_RD_CODE,
    FP_WR_LOCK1,
    FP_WR_LOCK2,
    FP_ERASE,
    FP_RD_SIG
  } fp_mode_e;

  localparam logic [3:0] SEL_WR_CODE  = 4'b0111;
  localparam logic [3:0] SEL_RD_CODE  = 4'b0011;
  localparam logic [3:0] SEL_WR_LOCK1 = 4'b1111;
  localparam logic [3:0] SEL_WR_LOCK2 = 4'b1100;
  localparam logic [3:0] SEL_ERASE    = 4'b1000;
  localparam logic [3:0] SEL_RD_SIG   = 4'b0000;

endpackage

// File: rtl/fp_mode_decode.sv
module fp_mode_decode
  import flashprog_pkg::*;
(
  input  logic       hv_en,
  input  logic       rst_pin,
  input  logic       strobe_n,
  input  logic [3:0] mode_sel,
  output fp_mode_e   mode
);

  always_comb begin
    mode = FP_IDLE;
    if (rst_pin && hv_en) begin
      unique case (mode_sel)
        SEL_WR_CODE:  mode = FP_WR_CODE;
        SEL_WR_LOCK1: mode = FP_WR_LOCK1;
        SEL_WR_LOCK2: mode = FP_WR_LOCK2;
        SEL_ERASE:    mode = FP_ERASE;
        default:      mode = FP_IDLE;
      endcase
    end else if (rst_pin && strobe_n) begin
      unique case (mode_sel)
        SEL_RD_CODE: mode = FP_RD_CODE;
        SEL_RD_SIG:  mode = FP_RD_SIG;
        default:     mode = FP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fp_addr_counter.sv
module fp_addr_counter #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin,
  input  logic              incr_pin,
  input  logic              hold,
  output logic [ADDR_W-1:0] addr
);

  logic              rst_pin_q;
  logic              incr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              clr_edge;
  logic              inc_edge;
  logic              addr_en;

  assign clr_edge = rst_pin & ~rst_pin_q;
  assign inc_edge = incr_pin & ~incr_q & ~hold;
  assign addr_en  = clr_edge | inc_edge;

  always_comb begin
    addr_d = addr_q;
    if (clr_edge) begin
      addr_d = '0;
    end else if (inc_edge) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pin_q <= 1'b0;
      incr_q    <= 1'b0;
      addr_q    <= '0;
    end else begin
      rst_pin_q <= rst_pin;
      incr_q    <= incr_pin;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

  assign addr = addr_q;

  AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin && !rst_pin_q) |=> (addr == '0)); // R1
  AST_ADDR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !(rst_pin && !rst_pin_q)) |=> $stable(addr)); // R10

endmodule

// File: rtl/fp_write_seq.sv
module fp_write_seq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 8,
  parameter int WRITE_CYC     = 60000,
  parameter int WRITE_MAX_CYC = 100000,
  parameter int ERASE_CYC     = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fp_mode_e          mode,
  input  logic              strobe_n,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_prog,
  output logic              busy,
  output logic              poll_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cmd_wr,
  output logic [1:0]        cmd_lock,
  output logic              cmd_erase
);

  localparam int CNT_W = $clog2(WRITE_CYC + 1);
  localparam int ER_W  = $clog2(ERASE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYC - 1);
  localparam logic [ER_W-1:0]  ER_LAST  = ER_W'(ERASE_CYC - 1);
  localparam logic [ER_W-1:0]  ER_SAT   = ER_W'(ERASE_CYC);

  logic              strobe_q;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  fp_mode_e          kind_q, kind_d;
  logic              cap_vld_q, cap_vld_d;
  fp_mode_e          cap_kind_q, cap_kind_d;
  logic [DATA_W-1:0] cap_data_q, cap_data_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;
  logic [ER_W-1:0]   er_cnt_q, er_cnt_d;

  logic fall, rise, wr_mode, allowed, start, done, er_arm;

  assign fall    = strobe_q & ~strobe_n;
  assign rise    = ~strobe_q & strobe_n;
  assign wr_mode = (mode == FP_WR_CODE) || (mode == FP_WR_LOCK1) || (mode == FP_WR_LOCK2);
  assign allowed = (cap_kind_q != FP_WR_CODE) || !lock_prog;
  assign start   = !busy_q && rise && cap_vld_q && allowed;
  assign done    = busy_q && (cnt_q == CNT_LAST);
  assign er_arm  = (mode == FP_ERASE) && !strobe_n && !busy_q;

  // next-state logic
  always_comb begin
    busy_d     = busy_q;
    cnt_d      = cnt_q;
    kind_d     = kind_q;
    cap_vld_d  = cap_vld_q;
    cap_kind_d = cap_kind_q;
    cap_data_d = cap_data_q;
    wr_addr_d  = wr_addr_q;
    wr_data_d  = wr_data_q;
    er_cnt_d   = '0;

    if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (done) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
    end else begin
      if (fall) begin
        cap_vld_d  = wr_mode;
        cap_kind_d = mode;
        cap_data_d = din;
      end
      if (rise) begin
        cap_vld_d = 1'b0;
      end
      if (start) begin
        busy_d    = 1'b1;
        cnt_d     = '0;
        kind_d    = cap_kind_q;
        wr_addr_d = addr;
        wr_data_d = cap_data_q;
      end
    end

    if (er_arm) begin
      er_cnt_d = (er_cnt_q == ER_SAT) ? er_cnt_q : er_cnt_q + 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b1;
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      kind_q     <= FP_IDLE;
      cap_vld_q  <= 1'b0;
      cap_kind_q <= FP_IDLE;
      cap_data_q <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      er_cnt_q   <= '0;
    end else begin
      strobe_q   <= strobe_n;
      busy_q     <= busy_d;
      cnt_q      <= cnt_d;
      kind_q     <= kind_d;
      cap_vld_q  <= cap_vld_d;
      cap_kind_q <= cap_kind_d;
      cap_data_q <= cap_data_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
      er_cnt_q   <= er_cnt_d;
    end
  end

  assign busy        = busy_q;
  assign poll_en     = busy_q && (kind_q == FP_WR_CODE);
  assign wr_addr     = wr_addr_q;
  assign wr_data     = wr_data_q;
  assign cmd_wr      = done && (kind_q == FP_WR_CODE);
  assign cmd_lock[0] = done && (kind_q == FP_WR_LOCK1);
  assign cmd_lock[1] = done && (kind_q == FP_WR_LOCK2);
  assign cmd_erase   = er_arm && (er_cnt_q == ER_LAST);

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (32'(cnt_q) < WRITE_CYC)); // R3
  AST_BUSY_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (32'(cnt_q) < WRITE_MAX_CYC)); // R3
  AST_WR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> !lock_prog); // R7
  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, cmd_lock, cmd_erase})); // R6
  AST_ERASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |-> !busy_q); // R6

endmodule

// File: rtl/fp_cell_array.sv
module fp_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        lock_wr,
  input  logic              erase,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lock
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [1:0]        lock_q, lock_d;

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '1;
      end
    end else if (wr) begin
      mem_q[waddr] <= mem_q[waddr] & wdata;
    end
  end

  always_comb begin
    lock_d = lock_q | lock_wr;
    if (erase) begin
      lock_d = 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 2'b00;
    end else begin
      lock_q <= lock_d;
    end
  end

  assign rdata = mem_q[raddr];
  assign lock  = lock_q;

  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lock == 2'b00)); // R6
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock[0] && !erase) |=> lock[0]); // R8
  AST_LOCK2_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock[1] && !erase) |=> lock[1]); // R8

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flashprog_pkg::*;
#(
  parameter int         ADDR_W        = 10,
  parameter int         DATA_W        = 8,
  parameter int         WRITE_CYC     = 60000,
  parameter int         WRITE_MAX_CYC = 100000,
  parameter int         ERASE_CYC     = 500000,
  parameter logic [7:0] SIG0          = 8'hA5,
  parameter logic [7:0] SIG1          = 8'h3C,
  parameter logic [7:0] SIG2          = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_en,
  input  logic              rst_pin,
  input  logic              strobe_n,
  input  logic [3:0]        mode_sel,
  input  logic              incr_pin,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              ready,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              arr_wr,
  output logic [1:0]        arr_lock_wr,
  output logic              arr_erase
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  fp_mode_e          mode;
  logic [ADDR_W-1:0] addr;
  logic              busy, poll_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rdata;
  logic [1:0]        lock;
  logic              cmd_wr, cmd_erase;
  logic [1:0]        cmd_lock;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  fp_mode_decode u_decode (
    .hv_en    (hv_en),
    .rst_pin  (rst_pin),
    .strobe_n (strobe_n),
    .mode_sel (mode_sel),
    .mode     (mode)
  );

  fp_addr_counter #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rst_pin  (rst_pin),
    .incr_pin (incr_pin),
    .hold     (busy),
    .addr     (addr)
  );

  fp_write_seq #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .WRITE_CYC     (WRITE_CYC),
    .WRITE_MAX_CYC (WRITE_MAX_CYC),
    .ERASE_CYC     (ERASE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode      (mode),
    .strobe_n  (strobe_n),
    .din       (din),
    .addr      (addr),
    .lock_prog (lock[0]),
    .busy      (busy),
    .poll_en   (poll_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd_wr    (cmd_wr),
    .cmd_lock  (cmd_lock),
    .cmd_erase (cmd_erase)
  );

  fp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr      (cmd_wr),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .lock_wr (cmd_lock),
    .erase   (cmd_erase),
    .raddr   (addr),
    .rdata   (rdata),
    .lock    (lock)
  );

  // read-data path
  always_comb begin
    dout = '1;
    unique case (mode)
      FP_RD_CODE: begin
        if (lock == 2'b11) begin
          dout = '1;
        end else if (poll_en && (addr == wr_addr)) begin
          dout = {~wr_data[DATA_W-1], rdata[DATA_W-2:0]};
        end else begin
          dout = rdata;
        end
      end
      FP_RD_SIG: begin
        if (addr == ADDR_W'(0)) begin
          dout = DATA_W'(SIG0);
        end else if (addr == ADDR_W'(1)) begin
          dout = DATA_W'(SIG1);
        end else if (addr == ADDR_W'(2)) begin
          dout = DATA_W'(SIG2);
        end else begin
          dout = '1;
        end
      end
      default: dout = '1;
    endcase
  end

  assign ready       = ~busy;
  assign arr_addr    = busy ? wr_addr : addr;
  assign arr_wdata   = wr_data;
  assign arr_wr      = cmd_wr;
  assign arr_lock_wr = cmd_lock;
  assign arr_erase   = cmd_erase;

  AST_READY_FALL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(ready) |-> $rose(strobe_n) || $past(strobe_n)); // R3
  AST_NO_ARRAY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n_int)
    (arr_wr || arr_lock_wr != 2'b00) |-> !ready); // R3

endmodule

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;

  localparam int WC = 40;
  localparam int WM = 64;
  localparam int EC = 100;
  localparam logic [7:0] S0 = 8'hA5;
  localparam logic [7:0] S1 = 8'h3C;
  localparam logic [7:0] S2 = 8'h96;
  localparam logic [3:0] M_WR = 4'b0111;
  localparam logic [3:0] M_RD = 4'b0011;
  localparam logic [3:0] M_L1 = 4'b1111;
  localparam logic [3:0] M_L2 = 4'b1100;
  localparam logic [3:0] M_ER = 4'b1000;
  localparam logic [3:0] M_SG = 4'b0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, hv_en, rst_pin, strobe_n, incr_pin;
  logic [3:0] mode_sel;
  logic [7:0] din, dout, arr_wdata;
  logic       ready, arr_wr, arr_erase;
  logic [9:0] arr_addr;
  logic [1:0] arr_lock_wr;

  flash_prog_ctrl #(
    .WRITE_CYC(WC), .WRITE_MAX_CYC(WM), .ERASE_CYC(EC),
    .SIG0(S0), .SIG1(S1), .SIG2(S2)
  ) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .rst_pin(rst_pin),
    .strobe_n(strobe_n), .mode_sel(mode_sel), .incr_pin(incr_pin),
    .din(din), .dout(dout), .ready(ready), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_wr(arr_wr), .arr_lock_wr(arr_lock_wr),
    .arr_erase(arr_erase)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] model [1024];
  bit lk1 = 0, lk2 = 0;
  int cur = 0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_code(input int a);
    return (lk1 && lk2) ? 8'hFF : model[a];
  endfunction

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic rst_edge();
    rst_pin = 1'b0; step();
    rst_pin = 1'b1; step();
    cur = 0;
  endtask

  task automatic incr_p();
    incr_pin = 1'b1; step();
    incr_pin = 1'b0; step();
    cur = (cur + 1) % 1024;
  endtask

  task automatic start_prog(input logic [3:0] sel, input logic [7:0] d);
    hv_en = 1'b1; mode_sel = sel; din = d; strobe_n = 1'b0; step();
    din = ~d; strobe_n = 1'b1; step();
  endtask

  task automatic rd(input string req);
    hv_en = 1'b0; mode_sel = M_RD; strobe_n = 1'b1; #1;
    check(req, dout, exp_code(cur));
  endtask

  task automatic wr_code(input logic [7:0] d, input string req, input bit timing);
    logic [7:0] old;
    old = model[cur];
    start_prog(M_WR, d);
    if (lk1) begin
      check(req, ready, 1);
      repeat (WC + 2) step();
      check(req, ready, 1);
    end else begin
      check(req, ready, 0);
      repeat (WC - 1) step();
      if (timing) check(req, ready, 0);
      step();
      check(req, ready, 1);
      model[cur] = old & d;
    end
  endtask

  task automatic wr_lock(input logic [3:0] sel, input string req);
    start_prog(sel, 8'h00);
    check(req, ready, 0);
    repeat (WC) step();
    check(req, ready, 1);
  endtask

  task automatic erase(input int lowcyc);
    hv_en = 1'b1; mode_sel = M_ER; strobe_n = 1'b0;
    repeat (lowcyc) step();
    strobe_n = 1'b1; step();
    if (lowcyc >= EC) begin
      for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
      lk1 = 0; lk2 = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; hv_en = 1'b0; rst_pin = 1'b0; strobe_n = 1'b1;
    incr_pin = 1'b0; mode_sel = M_SG; din = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R11: reset state
    check("R11 ready", ready, 1);
    check("R11 dout", dout, 8'hFF);
    check("R11 cmds", {arr_wr, arr_lock_wr, arr_erase}, 0);

    rst_edge();
    erase(EC + 2);                                   // R6 full erase
    rd("R6 erased");

    // R3 R4 directed write at address 0
    wr_code(8'h5A, "R3 write timing", 1);
    rd("R4 first write");
    wr_code(8'hF0, "R3 rewrite", 1);
    rd("R4 AND merge");
    check("R4 value", model[0], 8'h50);

    // R5 polling, R10 ignore during busy
    incr_p();
    begin
      logic [7:0] old;
      old = model[cur];
      start_prog(M_WR, 8'hC3);
      hv_en = 1'b0; mode_sel = M_RD; #1;
      check("R5 polling", dout, {1'b0, old[6:0]});
      incr_pin = 1'b1; step(); incr_pin = 1'b0; step();
      hv_en = 1'b1; mode_sel = M_WR; din = 8'h00; strobe_n = 1'b0; step();
      strobe_n = 1'b1; step();
      hv_en = 1'b0; mode_sel = M_RD; #1;
      check("R10 addr held", dout, {1'b0, old[6:0]});
      repeat (WC - 5) step();
      check("R3 still busy", ready, 0);
      step();
      check("R3 ready back", ready, 1);
      model[cur] = old & 8'hC3;
      rd("R5 true data");
      repeat (4) step();
      check("R10 no second write", ready, 1);
      rd("R10 data kept");
    end

    // R2 mode decode
    hv_en = 1'b1; mode_sel = M_RD; #1;
    check("R2 read needs low hv", dout, 8'hFF);
    hv_en = 1'b0; mode_sel = M_WR; #1;
    check("R2 idle dout", dout, 8'hFF);
    strobe_n = 1'b0; step(); strobe_n = 1'b1; step();
    check("R2 no write without hv", ready, 1);
    rd("R2 data unchanged");

    // R4 random writes
    for (int i = 0; i < 30; i++) begin
      int k;
      k = $urandom % 4;
      repeat (k) incr_p();
      wr_code(8'($urandom), "R4 random", 0);
      rd("R4 random readback");
    end

    // R1 wrap
    rst_edge();
    repeat (1023) incr_p();
    rd("R1 top address");
    incr_p();
    rd("R1 wrap to zero");

    // R9 signature
    rst_edge();
    hv_en = 1'b0; mode_sel = M_SG; #1;
    check("R9 sig0", dout, S0);
    incr_p(); mode_sel = M_SG; #1;
    check("R9 sig1", dout, S1);
    incr_p(); mode_sel = M_SG; #1;
    check("R9 sig2", dout, S2);
    incr_p(); mode_sel = M_SG; #1;
    check("R9 beyond", dout, 8'hFF);

    // R6 short erase does nothing
    erase(EC - 10);
    rst_edge();
    rd("R6 short erase");

    // R7 lock 1
    wr_lock(M_L1, "R7 lock1 write");
    lk1 = 1;
    wr_code(8'h00, "R7 write refused", 0);
    rd("R7 data kept");

    // R8 lock 2
    wr_lock(M_L2, "R8 lock2 write");
    lk2 = 1;
    rd("R8 verify blocked");
    erase(EC - 10);
    rd("R8 locks stay");

    // R6 erase clears locks
    erase(EC + 2);
    rst_edge();
    rd("R6 erase clears");
    wr_code(8'h12, "R6 write after erase", 1);
    rd("R6 write works");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule